// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two direction predictors side by side. The local predictor keeps a short outcome history for each branch, and that history picks one of its 2-bit counters. The global predictor mixes a register of recent outcomes from all branches with the branch address to pick one of its own 2-bit counters. A third table of selector entries, indexed by branch address, learns for each branch which of the two predictors has been right more often. Its verdict picks the final answer.

The lookup side is purely combinational. A fetch stage presents a PC and gets back the final direction and both component directions. It keeps the component directions and returns them with the resolved outcome on the update side. One valid update trains both counter tables, shifts the outcome into both histories and, when the two components had disagreed, moves the selector toward the one that was right. A parameter picks the selector flavour. With two bits of hysteresis it changes sides only after two consecutive wrong calls from a strong state. With a single bit it follows whichever component was right last.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, every local history entry and the global history register are zero, every component counter holds 1 (weakly not taken), and every selector entry holds 1 (weakly favouring local). Every lookup therefore returns 0 on all three prediction outputs.
- R2: Table indices fold the PC. For a W-bit index, bit k is the XOR of all PC bits i with i mod W equal to k. The local direction is bit 1 of the local counter addressed by the local history entry, and that entry is selected by the PC folded to LHT_BITS.
- R3: The global direction is bit 1 of the global counter at the global history XOR the PC folded to GHIST_W.
- R4: The final direction equals the global direction when bit 1 of the selector entry is 1, and the local direction otherwise. The selector entry is selected by the PC folded to CH_BITS. A lookup reflects the state before any update in the same cycle.
- R5: With CHOOSER_2BIT=1, the selector entry is a saturating counter from 0 to 3. On a disagreement it steps up by one when the global component was right and down by one when the local component was right.
- R6: With CHOOSER_2BIT=0, each disagreement sets the selector entry to 2 when the global component was right and to 1 when the local component was right.
- R7: A valid update whose two returned component directions are equal leaves the selector entry unchanged.
- R8: A valid update steps both addressed component counters, saturating, up by one if the branch was taken and down by one if not. The counters are addressed using the histories as they stood before the update. The outcome then enters bit 0 of the addressed local history entry and bit 0 of the global history, and older bits move up by one. With the valid input low, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupPc | input | PC_W | Address of the branch being predicted |
| predTaken | output | 1 | Final predicted direction |
| predLocal | output | 1 | Local component direction |
| predGlobal | output | 1 | Global component direction |
| updValid | input | 1 | A resolved branch is presented for training |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome, 1 for taken |
| updLocalPred | input | 1 | Local direction returned at lookup time |
| updGlobalPred | input | 1 | Global direction returned at lookup time |

## Verification
Three kinds of outcome stream are used. Heavily biased per-branch outcomes train the local and global counters toward saturation. Outcomes tied to the previous global outcome are ones only the global history can learn, so they separate the two component indices. Updates that carry disagreeing component directions, some of them deliberately wrong, drive the selector through its states. These show the two-step hysteresis apart from the single-bit flip, since both variants run side by side on identical stimulus. Updates with agreeing component directions are followed by lookups, which show that the selector stays where it was.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Counter encodings shared by the tables
  localparam logic [1:0] CTR_WEAK_NT    = 2'b01;
  localparam logic [1:0] SEL_WEAK_LOCAL = 2'b01;
  localparam logic [1:0] SEL_WEAK_GLOB  = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    logic histWr;        // shift outcome into local and global history
    logic ctrWr;         // train both component counters
    logic dirTaken;      // resolved outcome
    logic selWr;         // selector entry is written
    logic selToGlobal;   // global component was the right one
  } tpStrobe_t;

  function automatic logic [1:0] ctrStep(input logic [1:0] cur, input logic up);
    logic [1:0] nxt;
    nxt = cur;
    if (up && cur != 2'b11) nxt = cur + 2'd1;
    else if (!up && cur != 2'b00) nxt = cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/tp_pcfold.sv
module tp_pcfold #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  pcIn,
  output logic [OUT_W-1:0] idxOut
);

  always_comb begin
    idxOut = '0;
    for (int i = 0; i < IN_W; i++) begin
      idxOut[i % OUT_W] = idxOut[i % OUT_W] ^ pcIn[i];
    end
  end

endmodule

// File: rtl/tp_ctrl.sv
module tp_ctrl
  import tp_pkg::*;
(
  input  logic      updValid,
  input  logic      updTaken,
  input  logic      updLocalPred,
  input  logic      updGlobalPred,
  output tpStrobe_t strobe
);

  logic disagree;

  always_comb begin
    disagree           = updLocalPred ^ updGlobalPred;
    strobe.histWr      = updValid;
    strobe.ctrWr       = updValid;
    strobe.dirTaken    = updTaken;
    strobe.selWr       = updValid & disagree;
    strobe.selToGlobal = (updGlobalPred == updTaken);
  end

endmodule

// File: rtl/tp_datapath.sv
module tp_datapath
  import tp_pkg::*;
#(
  parameter int PC_W         = 16,
  parameter int LHT_BITS     = 4,
  parameter int LHIST_W      = 4,
  parameter int GHIST_W      = 6,
  parameter int CH_BITS      = 4,
  parameter bit CHOOSER_2BIT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PC_W-1:0]    lookupPc,
  input  logic [PC_W-1:0]    updPc,
  input  tpStrobe_t          strobe,
  output logic               predTaken,
  output logic               predLocal,
  output logic               predGlobal,
  output logic [GHIST_W-1:0] ghrOut
);

  localparam int LHT_N  = 1 << LHT_BITS;
  localparam int LCTR_N = 1 << LHIST_W;
  localparam int GCTR_N = 1 << GHIST_W;
  localparam int SEL_N  = 1 << CH_BITS;

  logic [LHIST_W-1:0] localHist [LHT_N];
  logic [1:0]         localCtr  [LCTR_N];
  logic [1:0]         globalCtr [GCTR_N];
  logic [1:0]         selCtr    [SEL_N];
  logic [GHIST_W-1:0] ghr;

  // Folded indices, lookup side and update side
  logic [LHT_BITS-1:0] lkLhtIdx, upLhtIdx;
  logic [GHIST_W-1:0]  lkPcG, upPcG;
  logic [CH_BITS-1:0]  lkSelIdx, upSelIdx;

  tp_pcfold #(.IN_W(PC_W), .OUT_W(LHT_BITS)) foldLkL (.pcIn(lookupPc), .idxOut(lkLhtIdx));
  tp_pcfold #(.IN_W(PC_W), .OUT_W(GHIST_W))  foldLkG (.pcIn(lookupPc), .idxOut(lkPcG));
  tp_pcfold #(.IN_W(PC_W), .OUT_W(CH_BITS))  foldLkS (.pcIn(lookupPc), .idxOut(lkSelIdx));
  tp_pcfold #(.IN_W(PC_W), .OUT_W(LHT_BITS)) foldUpL (.pcIn(updPc),    .idxOut(upLhtIdx));
  tp_pcfold #(.IN_W(PC_W), .OUT_W(GHIST_W))  foldUpG (.pcIn(updPc),    .idxOut(upPcG));
  tp_pcfold #(.IN_W(PC_W), .OUT_W(CH_BITS))  foldUpS (.pcIn(updPc),    .idxOut(upSelIdx));

  // Lookup path: history read, then counter read, then select
  logic [LHIST_W-1:0] lkLocIdx;
  logic [GHIST_W-1:0] lkGlbIdx;
  logic               lkUseGlobal;

  always_comb begin
    lkLocIdx    = localHist[lkLhtIdx];
    lkGlbIdx    = ghr ^ lkPcG;
    predLocal   = localCtr[lkLocIdx][1];
    predGlobal  = globalCtr[lkGlbIdx][1];
    lkUseGlobal = selCtr[lkSelIdx][1];
    predTaken   = lkUseGlobal ? predGlobal : predLocal;
  end

  // Update-side indices use pre-update histories
  logic [LHIST_W-1:0] upLocIdx;
  logic [GHIST_W-1:0] upGlbIdx;

  always_comb begin
    upLocIdx = localHist[upLhtIdx];
    upGlbIdx = ghr ^ upPcG;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LHT_N; i++) localHist[i] <= '0;
    end else if (strobe.histWr) begin
      localHist[upLhtIdx] <= {localHist[upLhtIdx][LHIST_W-2:0], strobe.dirTaken};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ghr <= '0;
    else if (strobe.histWr) ghr <= {ghr[GHIST_W-2:0], strobe.dirTaken};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LCTR_N; i++) localCtr[i] <= CTR_WEAK_NT;
    end else if (strobe.ctrWr) begin
      localCtr[upLocIdx] <= ctrStep(localCtr[upLocIdx], strobe.dirTaken);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < GCTR_N; i++) globalCtr[i] <= CTR_WEAK_NT;
    end else if (strobe.ctrWr) begin
      globalCtr[upGlbIdx] <= ctrStep(globalCtr[upGlbIdx], strobe.dirTaken);
    end
  end

  // Selector flavour chosen by parameter
  logic [1:0] selNext;

  generate
    if (CHOOSER_2BIT) begin : gSel2
      always_comb selNext = ctrStep(selCtr[upSelIdx], strobe.selToGlobal);
    end else begin : gSel1
      always_comb selNext = strobe.selToGlobal ? SEL_WEAK_GLOB : SEL_WEAK_LOCAL;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SEL_N; i++) selCtr[i] <= SEL_WEAK_LOCAL;
    end else if (strobe.selWr) begin
      selCtr[upSelIdx] <= selNext;
    end
  end

  assign ghrOut = ghr;

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
  import tp_pkg::*;
#(
  parameter int PC_W         = 16,
  parameter int LHT_BITS     = 4,
  parameter int LHIST_W      = 4,
  parameter int GHIST_W      = 6,
  parameter int CH_BITS      = 4,
  parameter bit CHOOSER_2BIT = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predTaken,
  output logic            predLocal,
  output logic            predGlobal,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic            updLocalPred,
  input  logic            updGlobalPred
);

  tpStrobe_t          strobe;
  logic [GHIST_W-1:0] ghrVal;

  tp_ctrl ctrl (
    .updValid      (updValid),
    .updTaken      (updTaken),
    .updLocalPred  (updLocalPred),
    .updGlobalPred (updGlobalPred),
    .strobe        (strobe)
  );

  tp_datapath #(
    .PC_W(PC_W), .LHT_BITS(LHT_BITS), .LHIST_W(LHIST_W),
    .GHIST_W(GHIST_W), .CH_BITS(CH_BITS), .CHOOSER_2BIT(CHOOSER_2BIT)
  ) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .lookupPc   (lookupPc),
    .updPc      (updPc),
    .strobe     (strobe),
    .predTaken  (predTaken),
    .predLocal  (predLocal),
    .predGlobal (predGlobal),
    .ghrOut     (ghrVal)
  );

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int GHIST_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               predTaken,
  input logic               predLocal,
  input logic               predGlobal,
  input logic               updValid,
  input logic               updTaken,
  input logic               updLocalPred,
  input logic               updGlobalPred,
  input logic [GHIST_W-1:0] ghr,
  input logic               selWr
);

  AST_RESET_HIST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> ghr == '0); // R1

  AST_AGREE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (predLocal == predGlobal) |-> (predTaken == predLocal)); // R4

  AST_PICK_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (predTaken == predLocal) || (predTaken == predGlobal)); // R4

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && (updLocalPred == updGlobalPred)) |-> !selWr); // R7

  AST_GHR_NEW: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> ghr[0] == $past(updTaken)); // R8

  AST_GHR_AGE: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> ghr[GHIST_W-1:1] == $past(ghr[GHIST_W-2:0])); // R8

  AST_GHR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(ghr)); // R8

endmodule

bind tournament_predictor tp_checker #(.GHIST_W(GHIST_W)) chk (
  .clk           (clk),
  .rstN          (rstN),
  .predTaken     (predTaken),
  .predLocal     (predLocal),
  .predGlobal    (predGlobal),
  .updValid      (updValid),
  .updTaken      (updTaken),
  .updLocalPred  (updLocalPred),
  .updGlobalPred (updGlobalPred),
  .ghr           (ghrVal),
  .selWr         (strobe.selWr)
);

// File: tb/tournament_predictor_test.sv
module tournament_predictor_test;

  localparam int PC_W = 16, LHT_BITS = 4, LHIST_W = 4, GHIST_W = 6, CH_BITS = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rstN = 1'b0;
  logic [PC_W-1:0] lookupPc = '0, updPc = '0;
  logic            updValid = 1'b0, updTaken = 1'b0, updLocalPred = 1'b0, updGlobalPred = 1'b0;
  logic            predTaken, predLocal, predGlobal;
  logic            fTaken, fLocal, fGlobal;

  tournament_predictor #(.CHOOSER_2BIT(1'b1)) uut (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc),
    .predTaken(predTaken), .predLocal(predLocal), .predGlobal(predGlobal),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .updLocalPred(updLocalPred), .updGlobalPred(updGlobalPred));

  tournament_predictor #(.CHOOSER_2BIT(1'b0)) uutFlip (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc),
    .predTaken(fTaken), .predLocal(fLocal), .predGlobal(fGlobal),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .updLocalPred(updLocalPred), .updGlobalPred(updGlobalPred));

  int total = 0, bad = 0;

  // Bench model state
  logic [LHIST_W-1:0] mLht [1 << LHT_BITS];
  logic [1:0]         mLoc [1 << LHIST_W];
  logic [1:0]         mGlb [1 << GHIST_W];
  logic [1:0]         mSel2 [1 << CH_BITS];
  logic [1:0]         mSel1 [1 << CH_BITS];
  logic [GHIST_W-1:0] mGhr;

  function automatic int fold(input logic [PC_W-1:0] pc, input int w);
    int r = 0;
    for (int i = 0; i < PC_W; i++) if (pc[i]) r = r ^ (1 << (i % w));
    return r;
  endfunction

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic expLocal(input logic [PC_W-1:0] pc);
    return mLoc[mLht[fold(pc, LHT_BITS)]][1];
  endfunction

  function automatic logic expGlobal(input logic [PC_W-1:0] pc);
    return mGlb[int'(mGhr) ^ fold(pc, GHIST_W)][1];
  endfunction

  function automatic logic expFinal(input logic [PC_W-1:0] pc, input bit twoBit);
    logic s;
    s = twoBit ? mSel2[fold(pc, CH_BITS)][1] : mSel1[fold(pc, CH_BITS)][1];
    return s ? expGlobal(pc) : expLocal(pc);
  endfunction

  task automatic modelReset();
    foreach (mLht[i]) mLht[i] = '0;
    foreach (mLoc[i]) mLoc[i] = 2'd1;
    foreach (mGlb[i]) mGlb[i] = 2'd1;
    foreach (mSel2[i]) mSel2[i] = 2'd1;
    foreach (mSel1[i]) mSel1[i] = 2'd1;
    mGhr = '0;
  endtask

  task automatic modelUpdate(input logic [PC_W-1:0] pc, input logic t, input logic lp, input logic gp);
    int li, ci, gi, si;
    li = fold(pc, LHT_BITS);
    ci = int'(mLht[li]);
    gi = int'(mGhr) ^ fold(pc, GHIST_W);
    si = fold(pc, CH_BITS);
    mLoc[ci] = sat(mLoc[ci], t);
    mGlb[gi] = sat(mGlb[gi], t);
    mLht[li] = {mLht[li][LHIST_W-2:0], t};
    mGhr = {mGhr[GHIST_W-2:0], t};
    if (lp != gp) begin
      mSel2[si] = sat(mSel2[si], gp == t);
      mSel1[si] = (gp == t) ? 2'd2 : 2'd1;
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Checks all outputs of both instances for the PC on lookupPc
  task automatic checkAll(input string selTag, input string flipTag);
    check("R2 local", predLocal, expLocal(lookupPc));
    check("R3 R8 global", predGlobal, expGlobal(lookupPc));
    check(selTag, predTaken, expFinal(lookupPc, 1'b1));
    check("R2 local flip", fLocal, expLocal(lookupPc));
    check("R3 R8 global flip", fGlobal, expGlobal(lookupPc));
    check(flipTag, fTaken, expFinal(lookupPc, 1'b0));
  endtask

  task automatic lookOnly(input logic [PC_W-1:0] pc, input string selTag, input string flipTag);
    @(negedge clk);
    lookupPc = pc;
    updValid = 1'b0;
    #1;
    checkAll(selTag, flipTag);
  endtask

  // Lookup and update in one cycle; lookup sees pre-update state (R4)
  task automatic step(input logic [PC_W-1:0] pc, input logic t, input logic lp, input logic gp,
                      input string selTag, input string flipTag);
    @(negedge clk);
    lookupPc = pc;
    updPc = pc;
    updTaken = t;
    updLocalPred = lp;
    updGlobalPred = gp;
    updValid = 1'b1;
    #1;
    checkAll(selTag, flipTag);
    @(posedge clk);
    #1;
    modelUpdate(pc, t, lp, gp);
    updValid = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stimulus
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, every output zero
    for (int p = 0; p < 16; p++) begin
      lookOnly(16'(p * 37), "R1 final", "R1 final flip");
      check("R1 zero", predTaken | predLocal | predGlobal | fTaken, 1'b0);
    end

    // R5/R6: selector hysteresis versus single-bit flip at one PC
    step(16'h0005, 1'b0, 1'b0, 1'b1, "R5 sel", "R6 sel");
    step(16'h0005, 1'b1, 1'b0, 1'b1, "R5 sel", "R6 sel");
    lookOnly(16'h0005, "R5 after one", "R6 after one");
    step(16'h0005, 1'b1, 1'b0, 1'b1, "R5 sel", "R6 sel");
    lookOnly(16'h0005, "R5 after two", "R6 after two");
    for (int k = 0; k < 4; k++) step(16'h0005, 1'b1, 1'b1, 1'b0, "R5 drive", "R6 drive");
    lookOnly(16'h0005, "R5 saturate", "R6 last");

    // R7: agreeing components leave the selector alone
    for (int k = 0; k < 6; k++) begin
      step(16'h0009, k[0], 1'b1, 1'b1, "R7 agree", "R7 agree flip");
      lookOnly(16'h0009, "R7 after", "R7 after flip");
    end

    // R8: idle cycles change nothing
    repeat (3) lookOnly(16'h0123, "R8 idle", "R8 idle flip");

    // Random mix of biased, history-correlated and mis-reported updates
    for (int n = 0; n < 1500; n++) begin
      logic [PC_W-1:0] pc;
      logic t, lp, gp;
      int sel;
      sel = int'($urandom % 8);
      pc = 16'(sel * 16'h0153 + 16'h0040);
      if (sel < 3)      t = ($urandom % 10) != 0;
      else if (sel < 5) t = mGhr[0] ^ sel[0];
      else              t = $urandom % 2;
      lp = expLocal(pc);
      gp = expGlobal(pc);
      if ($urandom % 6 == 0) begin
        lp = $urandom % 2;
        gp = $urandom % 2;
      end
      if ($urandom % 5 == 0) lookOnly(pc, "R4 final", "R6 final");
      else step(pc, t, lp, gp, "R4 R5 final", "R4 R6 final");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule